// File: doc/BRIEF.md
# Serial Port Interrupt Prioritizer

This block merges the four interrupt sources of a PC-style serial port into a single request line and an identification byte that host software reads to learn which source to service. Each source has a sticky pending flag. The flag is set by a one-cycle event pulse from the serial datapath and cleared by the register access that services that source. A source takes part in arbitration only while its enable bit is set. The identification byte always names the highest-priority source that is both pending and enabled.

The host-facing bus decoder drives the access strobes: a data register read, a data register write, an identification register read, a line status register read and a modem status register read. It also supplies the current enable nibble and the master interrupt-output bit from the modem control register. The external request line is active only while that master bit is set.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset all pending flags are clear, `iid` reads 8'h01 and `irq` is 0.
- R2: `iid` bit 0 is 1 when no enabled source is pending and 0 otherwise. Bits 3:1 carry the code of the reported source, and every bit above bit 3 is 0.
- R3: Priority runs from line status (iid 8'h06) to received data (8'h04) to transmitter empty (8'h02) to modem status (8'h00). Only the highest-priority source that is pending and enabled is reported.
- R4: The enable bits map as bit 0 = received data, bit 1 = transmitter empty, bit 2 = line status and bit 3 = modem status. A disabled source is not reported, but its flag stays latched and is reported once the source is enabled again.
- R5: `lsr_rd` clears the line status flag, `rbr_rd` clears the received-data flag and `msr_rd` clears the modem status flag.
- R6: `thr_wr` clears the transmitter-empty flag.
- R7: `iid_rd` clears the transmitter-empty flag only when the transmitter-empty code is the one being reported in that cycle. Otherwise the flag is left pending.
- R8: An event pulse on `src_evt[i]` (bit order as in R4) sets flag i at the next clock edge. If a set and a clear arrive in the same cycle, the set wins.
- R9: `irq` is 1 exactly when some enabled source is pending and `out_en` is 1.
- R10: When `int_en` is 4'b0000, `iid` reads 8'h01 and `irq` is 0 in the same cycle, with no clock edge needed.
- R11: An access strobe that belongs to one source does not clear the flag of any other source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_en | input | 4 | Per-source enable bits |
| src_evt | input | 4 | One-cycle event pulses that set the pending flags |
| rbr_rd | input | 1 | Data register read strobe |
| thr_wr | input | 1 | Data register write strobe |
| iid_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| out_en | input | 1 | Master interrupt-output enable |
| iid | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request line |

## Verification
The sources are raised one at a time in rising priority order, so that each new arrival must pre-empt the code already shown. They are then serviced from the top down, which shows that every clear exposes the next source in line. Strobes that belong to other sources are applied while a flag is pending, so that a clear reaching the wrong flag would show up in the reported code. Further patterns combine an identification read with a non-transmitter code, a set and a clear in the same cycle, a masked source that is later unmasked, and an enable nibble of zero applied between clock edges. Each of these separates one clearing or gating rule from the others.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int NSRC   = 4;
   localparam int CODE_W = 3;

   localparam int SRC_RX = 0;
   localparam int SRC_TX = 1;
   localparam int SRC_LS = 2;
   localparam int SRC_MS = 3;

   localparam logic [CODE_W-1:0] CODE_LS = 3'd3;
   localparam logic [CODE_W-1:0] CODE_RX = 3'd2;
   localparam logic [CODE_W-1:0] CODE_TX = 3'd1;
   localparam logic [CODE_W-1:0] CODE_MS = 3'd0;

   // source index at priority rank k (rank 0 = highest)
   function automatic int rank_src(input int k);
      case (k)
         0:       return SRC_LS;
         1:       return SRC_RX;
         2:       return SRC_TX;
         default: return SRC_MS;
      endcase
   endfunction

   function automatic logic [CODE_W-1:0] src_code(input int s);
      case (s)
         SRC_LS:  return CODE_LS;
         SRC_RX:  return CODE_RX;
         SRC_TX:  return CODE_TX;
         default: return CODE_MS;
      endcase
   endfunction
endpackage

// File: rtl/irq_src_flag.sv
module irq_src_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   generate
      if (SET_WINS) begin : g_set_wins
         always_ff @(posedge clk) begin
            if (!rst_n)     flag_q <= 1'b0;
            else if (set_i) flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
         end
      end else begin : g_clr_wins
         always_ff @(posedge clk) begin
            if (!rst_n)     flag_q <= 1'b0;
            else if (clr_i) flag_q <= 1'b0;
            else if (set_i) flag_q <= 1'b1;
         end
      end
   endgenerate

   assign flag_o = flag_q;

   // R5 R6: a clear without a competing set empties the flag
   p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
   // R8: an event with no competing clear latches
   p_event_latches_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !clr_i) |=> flag_o);
   // R11: no strobe, no event -> flag holds
   p_flag_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
   import uart_irq_pkg::*;
#(
   parameter int N  = NSRC,
   parameter int CW = CODE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req_i,
   output logic          any_o,
   output logic [CW-1:0] code_o,
   output logic [N-1:0]  grant_o
);
   generate
      if (N != NSRC) begin : g_bad_n
         $error("irq_prio_enc: N must equal the package source count");
      end
      if (CW < CODE_W) begin : g_bad_cw
         $error("irq_prio_enc: code width too small");
      end
   endgenerate

   always_comb begin
      grant_o = '0;
      code_o  = '0;
      // walk from lowest rank up so the highest pending rank wins
      for (int k = N - 1; k >= 0; k--) begin
         if (req_i[rank_src(k)]) begin
            grant_o = '0;
            grant_o[rank_src(k)] = 1'b1;
            code_o = CW'(src_code(rank_src(k)));
         end
      end
   end

   assign any_o = |req_i;

   // R3: at most one source granted
   p_single_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));
   // R3: line status beats all others
   p_ls_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[SRC_LS] |-> grant_o[SRC_LS]);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter int ID_W     = 8,
   parameter bit SET_WINS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [3:0]      int_en,
   input  logic [3:0]      src_evt,
   input  logic            rbr_rd,
   input  logic            thr_wr,
   input  logic            iid_rd,
   input  logic            lsr_rd,
   input  logic            msr_rd,
   input  logic            out_en,
   output logic [ID_W-1:0] iid,
   output logic            irq
);
   localparam int PAD_W = ID_W - CODE_W - 1;

   generate
      if (ID_W < CODE_W + 2) begin : g_bad_idw
         $error("uart_irq_prio: identification width too small");
      end
   endgenerate

   logic [NSRC-1:0]   pend;
   logic [NSRC-1:0]   clr;
   logic [NSRC-1:0]   req;
   logic [NSRC-1:0]   grant;
   logic [CODE_W-1:0] code;
   logic              any;

   always_comb begin
      clr         = '0;
      clr[SRC_RX] = rbr_rd;
      clr[SRC_TX] = thr_wr | (iid_rd & grant[SRC_TX]);
      clr[SRC_LS] = lsr_rd;
      clr[SRC_MS] = msr_rd;
   end

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         irq_src_flag #(.SET_WINS(SET_WINS)) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (src_evt[i]),
            .clr_i  (clr[i]),
            .flag_o (pend[i])
         );
      end
   endgenerate

   assign req = pend & int_en;

   irq_prio_enc #(.N(NSRC), .CW(CODE_W)) u_enc (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req),
      .any_o   (any),
      .code_o  (code),
      .grant_o (grant)
   );

   assign iid = {{PAD_W{1'b0}}, code, ~any};
   assign irq = any & out_en;

   // R9: output gated by master bit
   p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> !irq);
   // R10: all enables off -> idle immediately
   p_en_zero_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (int_en == 4'b0000) |-> (iid[0] && !irq));
   // R7: identification read while transmitter code shown clears it
   p_iid_read_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (iid_rd && !iid[0] && iid[3:1] == CODE_TX && !src_evt[SRC_TX]) |=> !pend[SRC_TX]);
   // R2: upper bits of the identification byte stay zero
   p_iid_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
      iid[ID_W-1:CODE_W+1] == '0);
endmodule

// File: tb/uart_irq_prio_test.sv
`timescale 1ns/1ps
module uart_irq_prio_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] int_en = 4'hF;
   logic [3:0] src_evt = '0;
   logic       rbr_rd = 0, thr_wr = 0, iid_rd = 0, lsr_rd = 0, msr_rd = 0;
   logic       out_en = 1'b1;
   logic [7:0] iid;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [7:0] q_iid[$];
   logic       q_irq[$];
   string      q_tag[$];

   always #2 clk = ~clk;

   uart_irq_prio uut (
      .clk(clk), .rst_n(rst_n), .int_en(int_en), .src_evt(src_evt),
      .rbr_rd(rbr_rd), .thr_wr(thr_wr), .iid_rd(iid_rd), .lsr_rd(lsr_rd),
      .msr_rd(msr_rd), .out_en(out_en), .iid(iid), .irq(irq)
   );

   task automatic compare(input logic [7:0] ei, input logic eq, input string tag);
      n_chk++;
      if (iid !== ei || irq !== eq) begin
         n_fail++;
         $display("FAIL %s: iid=%02h irq=%b expected iid=%02h irq=%b", tag, iid, irq, ei, eq);
      end
   endtask

   // monitor: pops one expected item per falling edge
   always @(negedge clk) begin
      if (q_iid.size() > 0) compare(q_iid.pop_front(), q_irq.pop_front(), q_tag.pop_front());
   end

   // driver: apply strobes for one cycle, queue the result expected after the edge
   task automatic step(input logic [3:0] evt, input logic rr, input logic tw,
                       input logic ir, input logic lr, input logic mr,
                       input logic [7:0] ei, input logic eq, input string tag);
      src_evt = evt; rbr_rd = rr; thr_wr = tw; iid_rd = ir; lsr_rd = lr; msr_rd = mr;
      @(posedge clk); #1;
      src_evt = '0; rbr_rd = 0; thr_wr = 0; iid_rd = 0; lsr_rd = 0; msr_rd = 0;
      q_iid.push_back(ei); q_irq.push_back(eq); q_tag.push_back(tag);
      @(negedge clk); #1;
   endtask

   initial begin
      #2000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: iid=%02h irq=%b expected run to complete", iid, irq);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #1;
      compare(8'h01, 1'b0, "R1 reset state");
      step(4'b0010, 0,0,0,0,0, 8'h02, 1, "R8 tx event latches");
      step(4'b0001, 0,0,0,0,0, 8'h04, 1, "R3 rx beats tx");
      step(4'b0100, 0,0,0,0,0, 8'h06, 1, "R3 ls beats rx");
      step(4'b1000, 0,0,0,0,0, 8'h06, 1, "R3 ms stays hidden");
      step(4'b0000, 0,0,0,1,0, 8'h04, 1, "R5 line status read");
      step(4'b0000, 0,0,1,0,0, 8'h04, 1, "R7 id read with rx shown");
      step(4'b0000, 1,0,0,0,0, 8'h02, 1, "R5 data read");
      step(4'b0000, 0,0,0,0,1, 8'h02, 1, "R11 modem read leaves tx");
      step(4'b0000, 0,0,1,0,0, 8'h01, 0, "R7 id read clears tx");
      step(4'b1000, 0,0,0,0,0, 8'h00, 1, "R3 modem code");
      int_en = 4'b1101;
      step(4'b0010, 0,0,0,0,0, 8'h00, 1, "R4 masked tx not shown");
      int_en = 4'hF;
      step(4'b0000, 0,0,0,0,0, 8'h02, 1, "R4 unmasked tx shown");
      step(4'b0000, 0,1,0,0,0, 8'h00, 1, "R6 data write clears tx");
      out_en = 1'b0;
      step(4'b0000, 0,0,0,0,0, 8'h00, 0, "R9 master bit off");
      out_en = 1'b1;
      step(4'b0100, 0,0,0,1,0, 8'h06, 1, "R8 set wins over clear");
      int_en = 4'b0000; #1;
      compare(8'h01, 1'b0, "R10 enables zero same cycle");
      int_en = 4'hF; #1;
      compare(8'h06, 1'b1, "R2 code restored");
      step(4'b0000, 0,0,0,1,1, 8'h01, 0, "R5 ls and modem read");
      step(4'b0001, 0,0,0,0,0, 8'h04, 1, "R8 rx event");
      step(4'b0000, 0,1,0,1,1, 8'h04, 1, "R11 foreign strobes keep rx");
      step(4'b0000, 1,0,0,0,0, 8'h01, 0, "R2 idle byte");
      @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule